// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine

This block produces one output of a finite impulse response filter: the sum, over every tap, of a stored coefficient times a delayed input sample. It owns the address logic for two external memories: a coefficient table and a ring buffer of recent samples. Both memories have one synchronous read port with one cycle of latency. A single signed multiplier feeds a wide accumulator, and operand fetch overlaps the arithmetic, so the loop body costs one cycle per tap.

New samples enter through a write strobe. The block forwards each one to the sample memory at its own write pointer and then moves the pointer on, wrapping modulo the tap count. A start pulse launches one output computation over the window that ends at the most recently written sample. Two preload cycles fill the operand registers, then the tap loop runs. On completion a one-cycle done pulse appears together with the new result. The result stays on the output until the next computation finishes.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0, `y_out` is 0 and `mem_waddr` is 0.
- R2: Each cycle with `wr_en` high drives `mem_we` high, with `mem_wdata` equal to `wr_data` and `mem_waddr` equal to the write pointer. The pointer then advances by one, wrapping from TAPS-1 to 0.
- R3: Samples and coefficients are two's complement DATA_W-bit values. Let k be the slot most recently written. A computation yields the sum over i = 0..TAPS-1 of coefficient[i] times sample slot (k - i) mod TAPS. Every computation starts from a cleared accumulator, so repeating a computation on the same data gives the same value.
- R4: `y_out` is a signed value 2*DATA_W + clog2(TAPS) bits wide. Sums in which every operand is at its most negative value, or every product is at its most negative value, are exact.
- R5: Start is sampled high at clock edge 0. `busy` is high from edge 0 to edge TAPS+2. `done` is high for exactly one cycle, which begins at edge TAPS+2. In that cycle `busy` is already low.
- R6: A start pulse that arrives while `busy` is high has no effect. Latency and result are unchanged and no extra done pulse follows.
- R7: `y_out` changes only at the edge that raises `done`, and it holds its value otherwise.
- R8: After the start edge, the coefficient read address counts up from 0, one step per cycle. The sample read address counts down from slot k, wrapping modulo TAPS. Both addresses stay below TAPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one output computation |
| wr_en | input | 1 | Accept a new sample |
| wr_data | input | DATA_W | New sample value |
| mem_we | output | 1 | Sample memory write enable |
| mem_waddr | output | clog2(TAPS) | Sample memory write address (write pointer) |
| mem_wdata | output | DATA_W | Sample memory write data |
| coef_raddr | output | clog2(TAPS) | Coefficient memory read address |
| coef_rdata | input | DATA_W | Coefficient read data, one cycle after address |
| smp_raddr | output | clog2(TAPS) | Sample memory read address |
| smp_rdata | input | DATA_W | Sample read data, one cycle after address |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | 2*DATA_W+clog2(TAPS) | Signed filter output |

## Verification
The bench builds the block with TAPS = 5 and DATA_W = 8. Five is not a power of two, so the address units take their compare-and-wrap branch instead of the natural binary rollover. With five taps the write pointer also wraps several times within a dozen writes. The narrow data width makes the extreme operands -128 and 127 cheap to drive. Five such products come within a few bits of the 19-bit accumulator limit, which exercises the sign extension and width margin directly.

// File: rtl/fir_pkg.sv
package fir_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOAD,
      ST_RUN
   } fir_state_e;
endpackage

// File: rtl/fir_agu.sv
// Modulo address unit: loads a base, then steps up or down by one with wrap.
module fir_agu #(
   parameter int DEPTH = 8,
   parameter bit DOWN  = 1'b0,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] nxt;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fir_agu: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         // binary rollover already wraps modulo DEPTH
         always_comb nxt = DOWN ? addr - AW'(1) : addr + AW'(1);
      end else begin : g_cmp
         localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
         always_comb begin
            if (DOWN) nxt = (addr == '0) ? TOP : addr - AW'(1);
            else      nxt = (addr == TOP) ? '0 : addr + AW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (step) addr <= nxt;
   end

   p_addr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(addr) < DEPTH);
endmodule

// File: rtl/fir_ctrl.sv
// Sequencer: accept start, two preload cycles, TAPS accumulate cycles, done.
module fir_ctrl import fir_pkg::*; #(
   parameter int TAPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic addr_load,
   output logic addr_step,
   output logic acc_clr,
   output logic op_load,
   output logic acc_en,
   output logic acc_last,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(TAPS);

   fir_state_e    state;
   logic [CW-1:0] cnt;
   logic          last_cnt;

   assign last_cnt  = (cnt == CW'(TAPS - 1));
   assign addr_load = (state == ST_IDLE) && start;
   assign acc_clr   = addr_load;
   assign addr_step = (state != ST_IDLE);
   assign op_load   = (state == ST_LOAD);
   assign acc_en    = (state == ST_RUN);
   assign acc_last  = (state == ST_RUN) && last_cnt;
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= acc_last;
         case (state)
            ST_IDLE:  if (start) state <= ST_FETCH;
            ST_FETCH: state <= ST_LOAD;
            ST_LOAD: begin
               state <= ST_RUN;
               cnt   <= '0;
            end
            ST_RUN: begin
               if (last_cnt) state <= ST_IDLE;
               else          cnt   <= cnt + CW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_run_uninterrupted_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !last_cnt) |=> (state == ST_RUN));
endmodule

// File: rtl/fir_mac.sv
// Operand registers, signed multiplier, wide accumulator and result register.
module fir_mac #(
   parameter int  W     = 16,
   parameter int  TAPS  = 8,
   localparam int ACC_W = 2 * W + $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             op_load,
   input  logic             acc_en,
   input  logic             last,
   input  logic [W-1:0]     coef_in,
   input  logic [W-1:0]     smp_in,
   output logic [ACC_W-1:0] result
);
   logic signed [W-1:0]     op_c, op_s;
   logic signed [2*W-1:0]   prod;
   logic signed [ACC_W-1:0] acc, sum;

   assign prod = op_c * op_s;
   assign sum  = acc + {{(ACC_W - 2*W){prod[2*W-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_c   <= '0;
         op_s   <= '0;
         acc    <= '0;
         result <= '0;
      end else begin
         if (op_load || acc_en) begin
            op_c <= coef_in;
            op_s <= smp_in;
         end
         if (clr)         acc <= '0;
         else if (acc_en) acc <= sum;
         if (last) result <= sum;
      end
   end
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine import fir_pkg::*; #(
   parameter int  DATA_W = 16,
   parameter int  TAPS   = 8,
   localparam int AW     = $clog2(TAPS),
   localparam int ACC_W  = 2 * DATA_W + $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [AW-1:0]     coef_raddr,
   input  logic [DATA_W-1:0] coef_rdata,
   output logic [AW-1:0]     smp_raddr,
   input  logic [DATA_W-1:0] smp_rdata,
   output logic              busy,
   output logic              done,
   output logic [ACC_W-1:0]  y_out
);
   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("fir_mac_engine: TAPS must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("fir_mac_engine: DATA_W must be at least 2");
      end
   endgenerate

   logic          addr_load, addr_step, acc_clr, op_load, acc_en, acc_last;
   logic [AW-1:0] wptr, newest;

   assign newest    = (wptr == '0) ? AW'(TAPS - 1) : wptr - AW'(1);
   assign mem_we    = wr_en;
   assign mem_waddr = wptr;
   assign mem_wdata = wr_data;

   fir_agu #(.DEPTH(TAPS), .DOWN(1'b0)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
      .step(wr_en), .addr(wptr));

   fir_agu #(.DEPTH(TAPS), .DOWN(1'b0)) u_coef_agu (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val('0),
      .step(addr_step), .addr(coef_raddr));

   fir_agu #(.DEPTH(TAPS), .DOWN(1'b1)) u_smp_agu (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(newest),
      .step(addr_step), .addr(smp_raddr));

   fir_ctrl #(.TAPS(TAPS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .addr_load(addr_load), .addr_step(addr_step), .acc_clr(acc_clr),
      .op_load(op_load), .acc_en(acc_en), .acc_last(acc_last),
      .busy(busy), .done(done));

   fir_mac #(.W(DATA_W), .TAPS(TAPS)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .op_load(op_load),
      .acc_en(acc_en), .last(acc_last), .coef_in(coef_rdata),
      .smp_in(smp_rdata), .result(y_out));

   p_wptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_waddr == AW'(TAPS - 1)) |=> (mem_waddr == '0));
   p_y_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(y_out));
   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/sim_fir_mac_engine.sv
module sim_fir_mac_engine;
   localparam int  TAPS   = 5;
   localparam int  W      = 8;
   localparam int  AW     = $clog2(TAPS);
   localparam int  ACC_W  = 2 * W + $clog2(TAPS);
   localparam time PERIOD = 10ns;
   localparam int  NV     = 4;
   localparam int  NS     = 3;

   localparam logic signed [W-1:0] VC [NV][TAPS] = '{
      '{8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd5},
      '{-8'sd1, 8'sd0, 8'sd1, 8'sd0, -8'sd1},
      '{8'sd127, -8'sd128, 8'sd64, -8'sd64, 8'sd1},
      '{8'sd3, 8'sd3, 8'sd3, 8'sd3, 8'sd3}};
   localparam logic signed [W-1:0] VS [NV][NS] = '{
      '{8'sd10, -8'sd3, 8'sd7},
      '{8'sd100, -8'sd50, 8'sd25},
      '{-8'sd128, 8'sd127, -8'sd1},
      '{8'sd0, -8'sd7, 8'sd9}};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic mem_we, busy, done;
   logic [AW-1:0] mem_waddr, coef_raddr, smp_raddr;
   logic [W-1:0] mem_wdata, coef_rdata, smp_rdata;
   logic signed [ACC_W-1:0] y_out;

   logic signed [W-1:0] coef_mem [TAPS];
   logic signed [W-1:0] smp_mem  [TAPS];
   logic signed [W-1:0] mdl      [TAPS];
   int mptr = 0;
   int total = 0, bad = 0;

   always #(PERIOD / 2) clk = ~clk;

   fir_mac_engine #(.DATA_W(W), .TAPS(TAPS)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_data(wr_data),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
      .smp_raddr(smp_raddr), .smp_rdata(smp_rdata),
      .busy(busy), .done(done), .y_out(y_out));

   always @(posedge clk) begin
      coef_rdata <= coef_mem[coef_raddr];
      smp_rdata  <= smp_mem[smp_raddr];
      if (mem_we) smp_mem[mem_waddr] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint exp_y();
      longint s = 0;
      int nw = (mptr + TAPS - 1) % TAPS;
      for (int i = 0; i < TAPS; i++)
         s += longint'(coef_mem[i]) * longint'(mdl[(nw - i + TAPS) % TAPS]);
      return s;
   endfunction

   task automatic write_smp(input logic signed [W-1:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      #1;
      chk(mem_we === 1'b1 && int'(mem_waddr) == mptr && mem_wdata === v,
          "R2 write address", longint'(mem_waddr), longint'(mptr));
      @(negedge clk);
      wr_en = 1'b0;
      mdl[mptr] = v;
      mptr = (mptr + 1) % TAPS;
   endtask

   task automatic run_calc(input string tag, input int poke, output longint res);
      int lat, ndone, nw;
      bit addr_ok;
      nw = (mptr + TAPS - 1) % TAPS;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      addr_ok = 1'b1;
      chk(busy === 1'b1, {"R5 busy after start ", tag}, longint'(busy), 1);
      while (done !== 1'b1 && lat < 60) begin
         if (lat <= TAPS &&
             (int'(smp_raddr) != (nw - (lat - 1) + TAPS) % TAPS || int'(coef_raddr) != lat - 1))
            addr_ok = 1'b0;
         start = (lat == poke);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk(addr_ok, {"R8 address sequence ", tag}, longint'(addr_ok), 1);
      chk(lat == TAPS + 3, {"R5 latency ", tag}, lat, TAPS + 3);
      res = longint'(y_out);
      ndone = 0;
      repeat (TAPS + 4) begin
         @(negedge clk);
         if (done === 1'b1) ndone++;
      end
      chk(ndone == 0, {"R5 R6 single done ", tag}, ndone, 0);
   endtask

   initial begin
      #(PERIOD * 20000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      longint r, r2, y0;
      for (int i = 0; i < TAPS; i++) begin
         coef_mem[i] = '0;
         smp_mem[i] = '0;
         mdl[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", longint'({busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R1 busy", longint'(busy), 0);
      chk(done === 1'b0, "R1 done", longint'(done), 0);
      chk(y_out === '0, "R1 result", longint'(y_out), 0);
      chk(mem_waddr === '0, "R1 write pointer", longint'(mem_waddr), 0);

      // table-driven vectors (R3, R5, R8 with R2 on each write)
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < TAPS; i++) coef_mem[i] = VC[v][i];
         for (int s = 0; s < NS; s++) write_smp(VS[v][s]);
         run_calc($sformatf("vec%0d", v), 0, r);
         chk(r == exp_y(), $sformatf("R3 vector %0d", v), r, exp_y());
      end

      // R7: result held while idle
      y0 = longint'(y_out);
      repeat (10) @(negedge clk);
      chk(longint'(y_out) == y0, "R7 idle hold", longint'(y_out), y0);

      // R3: accumulator cleared, repeat gives same value
      run_calc("repeat", 0, r2);
      chk(r2 == y0, "R3 repeat clears accumulator", r2, y0);

      // R6: start pulses during busy
      run_calc("poke2", 2, r);
      chk(r == exp_y(), "R6 start in preload ignored", r, exp_y());
      run_calc("poke6", 6, r);
      chk(r == exp_y(), "R6 start in loop ignored", r, exp_y());

      // R4: extreme operands
      for (int i = 0; i < TAPS; i++) coef_mem[i] = -8'sd128;
      for (int s = 0; s < TAPS; s++) write_smp(-8'sd128);
      run_calc("max", 0, r);
      chk(r == 81920, "R4 largest positive sum", r, 81920);
      for (int i = 0; i < TAPS; i++) coef_mem[i] = 8'sd127;
      run_calc("min", 0, r);
      chk(r == -81280, "R4 largest negative sum", r, -81280);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule